// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit processor's 16-bit address bus and the memories and peripherals around it. On each access it decides, without adding a cycle, which target responds. The targets are main RAM, an 8 KB BASIC-style ROM, a 4 KB character ROM, an 8 KB kernel ROM, a 4-bit-wide colour RAM, or a register window of the video, sound, two timer or expansion devices. It also returns the read data from the chosen source. The memories and devices live outside the block. The block drives a select for each of them and a shared local offset, and takes back their read data.

The bank layout is set by a processor-internal I/O port held inside the block. A direction register sits at address 0 and a data register at address 1. Each bank-control bit is taken from an effective port value equal to the inverted direction register ORed with the data register. A pin configured as input therefore counts as 1. Reads in the spare I/O pages return the last byte seen on the video bus, which gives an open-bus value. Colour RAM reads merge in the upper nibble of that byte.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset both port registers are 0. Reading address 0 then returns 0x00 and reading address 1 returns 0x17. Reads map the BASIC ROM at $A000-$BFFF, the I/O region at $D000-$DFFF and the kernel ROM at $E000-$FFFF.
- R2: With effective value E = ~dir | data: a read in $A000-$BFFF selects the BASIC ROM when E[1:0] = 11 and RAM otherwise; a read in $E000-$FFFF selects the kernel ROM when E[1] = 1 and RAM otherwise.
- R3: In $D000-$DFFF, the I/O region is mapped when E[1:0] != 00 and E[2] = 1. Otherwise a read selects the character ROM when E[1:0] != 00 and E[2] = 0, and selects RAM in all remaining cases. A write always goes to RAM when the I/O region is not mapped.
- R4: With the I/O region mapped, address bits 11:8 select the device. Values 0-3 select video (offset = addr[5:0]), 4-7 sound (addr[4:0]), 8-11 colour RAM (addr[9:0]), 12 timer 1 (addr[3:0]) and 13 timer 2 (addr[3:0]). $DF00-$DF0F selects the expansion unit (addr[3:0]). ROM offsets are addr[12:0] for BASIC and kernel and addr[11:0] for the character ROM. Every other access gives offset 0.
- R5: A colour RAM read returns {video-bus byte[7:4], colour data[3:0]}. A colour RAM write presents wdata[3:0] as the stored nibble.
- R6: With the I/O region mapped, a read in $DE00-$DFFF outside $DF00-$DF0F returns the last video-bus byte and selects no target. A write there selects nothing.
- R7: A write in a ROM-mapped range selects RAM with the write strobe and the unchanged write data, and never selects a ROM.
- R8: Reading address 0 returns the direction register. Reading address 1 returns (dir & data) | (~dir & 0x17). Neither read selects RAM.
- R9: A write to address 0 (direction) or 1 (data) loads that register at the clock edge. The same access writes the last video-bus byte into RAM at that address. The new bank layout applies from the next access.
- R10: At most one target select is active per access, and none is active when neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| vbus_last | input | 8 | Last byte seen on the video bus |
| ram_rdata | input | 8 | RAM read data |
| basic_rdata | input | 8 | BASIC ROM read data |
| char_rdata | input | 8 | Character ROM read data |
| kern_rdata | input | 8 | Kernel ROM read data |
| col_rdata | input | 4 | Colour RAM read nibble |
| vid_rdata | input | 8 | Video register read data |
| snd_rdata | input | 8 | Sound register read data |
| tmr1_rdata | input | 8 | Timer 1 read data |
| tmr2_rdata | input | 8 | Timer 2 read data |
| exp_rdata | input | 8 | Expansion unit read data |
| ram_sel | output | 1 | RAM select |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| basic_sel | output | 1 | BASIC ROM select |
| char_sel | output | 1 | Character ROM select |
| kern_sel | output | 1 | Kernel ROM select |
| col_sel | output | 1 | Colour RAM select |
| col_wdata | output | 4 | Colour RAM write nibble |
| vid_sel | output | 1 | Video register select |
| snd_sel | output | 1 | Sound register select |
| tmr1_sel | output | 1 | Timer 1 select |
| tmr2_sel | output | 1 | Timer 2 select |
| exp_sel | output | 1 | Expansion unit select |
| loc_off | output | 13 | Local offset inside the selected target |
| rdata | output | 8 | Read data to the processor |

## Verification
The hardest cases to reach are the bank layouts that need a particular mix of direction and data bits. One example is a direction bit set to output and driving 0 while its neighbours are inputs. These layouts only arise after a chosen pair of port writes. The stimulus therefore mixes random writes to addresses 0 and 1 with random accesses weighted towards the $A000, $D000, $DE00 and $E000 ranges. This visits all eight layouts and crosses each with every region. Directed steps cover reset, the port read-back formula, the video-bus write-through on port writes, the colour nibble merge and the open-bus pages.

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  input  logic [7:0]  vbus_last,
  input  logic [7:0]  ram_rdata,
  input  logic [7:0]  basic_rdata,
  input  logic [7:0]  char_rdata,
  input  logic [7:0]  kern_rdata,
  input  logic [3:0]  col_rdata,
  input  logic [7:0]  vid_rdata,
  input  logic [7:0]  snd_rdata,
  input  logic [7:0]  tmr1_rdata,
  input  logic [7:0]  tmr2_rdata,
  input  logic [7:0]  exp_rdata,
  output logic        ram_sel,
  output logic        ram_we,
  output logic [7:0]  ram_wdata,
  output logic        basic_sel,
  output logic        char_sel,
  output logic        kern_sel,
  output logic        col_sel,
  output logic [3:0]  col_wdata,
  output logic        vid_sel,
  output logic        snd_sel,
  output logic        tmr1_sel,
  output logic        tmr2_sel,
  output logic        exp_sel,
  output logic [12:0] loc_off,
  output logic [7:0]  rdata
);

  localparam logic [7:0] PORT_PULL = 8'h17;

  logic [7:0] dir_q, dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 8'h00;
      dat_q <= 8'h00;
    end else if (wr_en && addr == 16'h0000) begin
      dir_q <= wdata;
    end else if (wr_en && addr == 16'h0001) begin
      dat_q <= wdata;
    end
  end

  wire [7:0] eff      = ~dir_q | dat_q;
  wire       lo_any   = |eff[1:0];
  wire       basic_in = &eff[1:0];
  wire       kern_in  = eff[1];
  wire       char_in  = lo_any & ~eff[2];
  wire       io_in    = lo_any &  eff[2];

  wire       acc      = rd_en | wr_en;
  wire [3:0] hi       = addr[15:12];
  wire [3:0] pg       = addr[11:8];
  wire       is_port  = (addr[15:1] == 15'd0);
  wire       in_basic = (hi == 4'hA) || (hi == 4'hB);
  wire       in_dpage = (hi == 4'hD);
  wire       in_kern  = (hi == 4'hE) || (hi == 4'hF);
  wire       io_hit   = acc & in_dpage & io_in;

  wire basic_hit = rd_en & in_basic & basic_in;
  wire kern_hit  = rd_en & in_kern & kern_in;
  wire char_hit  = rd_en & in_dpage & ~io_in & char_in;
  wire vid_hit   = io_hit & (pg[3:2] == 2'b00);
  wire snd_hit   = io_hit & (pg[3:2] == 2'b01);
  wire col_hit   = io_hit & (pg[3:2] == 2'b10);
  wire t1_hit    = io_hit & (pg == 4'hC);
  wire t2_hit    = io_hit & (pg == 4'hD);
  wire exp_hit   = io_hit & (pg == 4'hF) & (addr[7:4] == 4'h0);
  wire open_hit  = io_hit & (pg[3:1] == 3'b111) & ~exp_hit;
  wire ram_hit   = acc & ~(in_dpage & io_in) & ~basic_hit & ~kern_hit
                 & ~char_hit & ~(is_port & rd_en);

  assign ram_sel   = ram_hit;
  assign ram_we    = ram_hit & wr_en;
  assign ram_wdata = is_port ? vbus_last : wdata;
  assign basic_sel = basic_hit;
  assign char_sel  = char_hit;
  assign kern_sel  = kern_hit;
  assign col_sel   = col_hit;
  assign col_wdata = wdata[3:0];
  assign vid_sel   = vid_hit;
  assign snd_sel   = snd_hit;
  assign tmr1_sel  = t1_hit;
  assign tmr2_sel  = t2_hit;
  assign exp_sel   = exp_hit;

  always_comb begin
    loc_off = 13'd0;
    if (basic_hit || kern_hit) loc_off = addr[12:0];
    else if (char_hit)         loc_off = {1'b0, addr[11:0]};
    else if (col_hit)          loc_off = {3'b0, addr[9:0]};
    else if (vid_hit)          loc_off = {7'b0, addr[5:0]};
    else if (snd_hit)          loc_off = {8'b0, addr[4:0]};
    else if (t1_hit || t2_hit || exp_hit) loc_off = {9'b0, addr[3:0]};
  end

  always_comb begin
    rdata = ram_rdata;
    if (is_port)        rdata = addr[0] ? ((dir_q & dat_q) | (~dir_q & PORT_PULL)) : dir_q;
    else if (basic_hit) rdata = basic_rdata;
    else if (kern_hit)  rdata = kern_rdata;
    else if (char_hit)  rdata = char_rdata;
    else if (vid_hit)   rdata = vid_rdata;
    else if (snd_hit)   rdata = snd_rdata;
    else if (col_hit)   rdata = {vbus_last[7:4], col_rdata};
    else if (t1_hit)    rdata = tmr1_rdata;
    else if (t2_hit)    rdata = tmr2_rdata;
    else if (exp_hit)   rdata = exp_rdata;
    else if (open_hit)  rdata = vbus_last;
  end

  wire [9:0] sel_vec = {ram_sel, basic_sel, char_sel, kern_sel, col_sel,
                        vid_sel, snd_sel, tmr1_sel, tmr2_sel, exp_sel};

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> (sel_vec == 10'd0));

  assert_rom_write_to_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (in_basic || in_kern)) |-> (ram_we && ram_wdata == wdata && !basic_sel && !kern_sel));

  assert_dir_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'h0000) |=> (dir_q == $past(wdata)));

  assert_port_write_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_port) |-> (ram_we && ram_wdata == vbus_last));

  assert_colour_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && col_sel) |-> (rdata == {vbus_last[7:4], col_rdata}));

  assert_open_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_dpage && io_in && pg[3:1] == 3'b111 && !exp_sel) |-> (rdata == vbus_last && sel_vec == 10'd0));

endmodule

// File: tb/mem_bank_decoder_tb.sv
module mem_bank_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0, vbus_last = '0;
  logic [7:0] ram_rdata = '0, basic_rdata = '0, char_rdata = '0, kern_rdata = '0;
  logic [3:0] col_rdata = '0;
  logic [7:0] vid_rdata = '0, snd_rdata = '0, tmr1_rdata = '0, tmr2_rdata = '0, exp_rdata = '0;
  logic ram_sel, ram_we, basic_sel, char_sel, kern_sel, col_sel;
  logic vid_sel, snd_sel, tmr1_sel, tmr2_sel, exp_sel;
  logic [7:0] ram_wdata, rdata;
  logic [3:0] col_wdata;
  logic [12:0] loc_off;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_dir = 8'h00, m_dat = 8'h00;

  always #2 clk = ~clk;

  mem_bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .vbus_last(vbus_last), .ram_rdata(ram_rdata),
    .basic_rdata(basic_rdata), .char_rdata(char_rdata), .kern_rdata(kern_rdata),
    .col_rdata(col_rdata), .vid_rdata(vid_rdata), .snd_rdata(snd_rdata),
    .tmr1_rdata(tmr1_rdata), .tmr2_rdata(tmr2_rdata), .exp_rdata(exp_rdata),
    .ram_sel(ram_sel), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .basic_sel(basic_sel), .char_sel(char_sel), .kern_sel(kern_sel),
    .col_sel(col_sel), .col_wdata(col_wdata), .vid_sel(vid_sel), .snd_sel(snd_sel),
    .tmr1_sel(tmr1_sel), .tmr2_sel(tmr2_sel), .exp_sel(exp_sel),
    .loc_off(loc_off), .rdata(rdata)
  );

  // select order: ram basic char kern col vid snd t1 t2 exp
  function automatic logic [9:0] exp_sel_f(input logic [15:0] a, input logic r, input logic w,
                                           input logic [7:0] d, input logic [7:0] p);
    logic [7:0] e;
    logic [3:0] page;
    e = ~d | p;
    page = a[11:8];
    exp_sel_f = '0;
    if (!(r || w)) return exp_sel_f;
    if (a < 16'h0002) begin
      if (w) exp_sel_f[9] = 1'b1;
    end else if (a >= 16'hA000 && a <= 16'hBFFF) begin
      if (r && e[1] && e[0]) exp_sel_f[8] = 1'b1; else exp_sel_f[9] = 1'b1;
    end else if (a >= 16'hE000) begin
      if (r && e[1]) exp_sel_f[6] = 1'b1; else exp_sel_f[9] = 1'b1;
    end else if (a >= 16'hD000 && a <= 16'hDFFF) begin
      if ((e[1] || e[0]) && e[2]) begin
        if (page <= 4'd3) exp_sel_f[4] = 1'b1;
        else if (page <= 4'd7) exp_sel_f[3] = 1'b1;
        else if (page <= 4'd11) exp_sel_f[5] = 1'b1;
        else if (page == 4'd12) exp_sel_f[2] = 1'b1;
        else if (page == 4'd13) exp_sel_f[1] = 1'b1;
        else if (a >= 16'hDF00 && a <= 16'hDF0F) exp_sel_f[0] = 1'b1;
      end else if (r && (e[1] || e[0])) exp_sel_f[7] = 1'b1;
      else exp_sel_f[9] = 1'b1;
    end else begin
      exp_sel_f[9] = 1'b1;
    end
  endfunction

  function automatic logic [12:0] exp_off_f(input logic [9:0] s, input logic [15:0] a);
    if (s[8] || s[6]) return a[12:0];
    if (s[7]) return {1'b0, a[11:0]};
    if (s[5]) return {3'b0, a[9:0]};
    if (s[4]) return {7'b0, a[5:0]};
    if (s[3]) return {8'b0, a[4:0]};
    if (s[2] || s[1] || s[0]) return {9'b0, a[3:0]};
    return 13'd0;
  endfunction

  function automatic logic [7:0] exp_rd_f(input logic [9:0] s, input logic [15:0] a,
                                          input logic [7:0] d, input logic [7:0] p);
    if (a == 16'h0000) return d;
    if (a == 16'h0001) return (d & p) | (~d & 8'h17);
    if (s[9]) return ram_rdata;
    if (s[8]) return basic_rdata;
    if (s[7]) return char_rdata;
    if (s[6]) return kern_rdata;
    if (s[5]) return {vbus_last[7:4], col_rdata};
    if (s[4]) return vid_rdata;
    if (s[3]) return snd_rdata;
    if (s[2]) return tmr1_rdata;
    if (s[1]) return tmr2_rdata;
    if (s[0]) return exp_rdata;
    return vbus_last;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", req, what, addr, act, expv);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d,
                        input string req);
    logic [9:0] es;
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w; wdata = d;
    vbus_last = 8'($urandom); ram_rdata = 8'($urandom); basic_rdata = 8'($urandom);
    char_rdata = 8'($urandom); kern_rdata = 8'($urandom); col_rdata = 4'($urandom);
    vid_rdata = 8'($urandom); snd_rdata = 8'($urandom); tmr1_rdata = 8'($urandom);
    tmr2_rdata = 8'($urandom); exp_rdata = 8'($urandom);
    #1;
    es = exp_sel_f(a, r, w, m_dir, m_dat);
    chk(req, "selects", {6'd0, ram_sel, basic_sel, char_sel, kern_sel, col_sel,
                         vid_sel, snd_sel, tmr1_sel, tmr2_sel, exp_sel}, {6'd0, es});
    chk(req, "ram_we", {15'd0, ram_we}, {15'd0, es[9] & w});
    if (w && es[9]) chk(req, "ram_wdata", {8'd0, ram_wdata}, {8'd0, (a < 16'h0002) ? vbus_last : d});
    if (w && es[5]) chk(req, "col_wdata", {12'd0, col_wdata}, {12'd0, d[3:0]});
    chk(req, "loc_off", {3'd0, loc_off}, {3'd0, exp_off_f(es, a)});
    if (r) chk(req, "rdata", {8'd0, rdata}, {8'd0, exp_rd_f(es, a, m_dir, m_dat)});
    if (w && a == 16'h0000) m_dir = d;
    if (w && a == 16'h0001) m_dat = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_port(input logic [7:0] d, input logic [7:0] p);
    access(16'h0000, 1'b0, 1'b1, d, "R9");
    access(16'h0001, 1'b0, 1'b1, p, "R9");
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 8)
      0: return 16'($urandom % 2);
      1: return 16'($urandom % 16'hA000);
      2: return 16'hA000 + 16'($urandom % 16'h2000);
      3: return 16'hD000 + 16'($urandom % 16'h1000);
      4: return 16'hDE00 + 16'($urandom % 16'h0200);
      5: return 16'hE000 + 16'($urandom % 16'h2000);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C64));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    access(16'h0000, 1'b1, 1'b0, 8'h00, "R1");
    access(16'h0001, 1'b1, 1'b0, 8'h00, "R1");
    access(16'hA123, 1'b1, 1'b0, 8'h00, "R1");
    access(16'hE456, 1'b1, 1'b0, 8'h00, "R1");
    access(16'hD020, 1'b1, 1'b0, 8'h00, "R1");
    // R8 read-back formula
    set_port(8'hF0, 8'h5A);
    access(16'h0000, 1'b1, 1'b0, 8'h00, "R8");
    access(16'h0001, 1'b1, 1'b0, 8'h00, "R8");
    // R4 device pages, R5 colour, R6 open bus
    set_port(8'h00, 8'h00);
    access(16'hD3FF, 1'b1, 1'b0, 8'h00, "R4");
    access(16'hD41F, 1'b1, 1'b0, 8'h00, "R4");
    access(16'hDC0F, 1'b1, 1'b0, 8'h00, "R4");
    access(16'hDD03, 1'b1, 1'b0, 8'h00, "R4");
    access(16'hDF0F, 1'b1, 1'b0, 8'h00, "R4");
    access(16'hD9A5, 1'b1, 1'b0, 8'h00, "R5");
    access(16'hDBFF, 1'b0, 1'b1, 8'hC7, "R5");
    access(16'hDE00, 1'b1, 1'b0, 8'h00, "R6");
    access(16'hDF10, 1'b1, 1'b0, 8'h00, "R6");
    access(16'hDFFF, 1'b1, 1'b0, 8'h00, "R6");
    access(16'hDE80, 1'b0, 1'b1, 8'h11, "R6");
    // R7 writes under ROM
    access(16'hA000, 1'b0, 1'b1, 8'h3C, "R7");
    access(16'hFFFF, 1'b0, 1'b1, 8'hA5, "R7");
    // R3 char ROM and all-RAM layouts
    set_port(8'h07, 8'h03);
    access(16'hD800, 1'b1, 1'b0, 8'h00, "R3");
    access(16'hD800, 1'b0, 1'b1, 8'h42, "R3");
    set_port(8'h07, 8'h04);
    access(16'hD000, 1'b1, 1'b0, 8'h00, "R3");
    access(16'hA000, 1'b1, 1'b0, 8'h00, "R2");
    access(16'hE000, 1'b1, 1'b0, 8'h00, "R2");
    // R10 idle cycle
    access(16'hD000, 1'b0, 1'b0, 8'h00, "R10");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 10 == 0)
        set_port(8'h07 & 8'($urandom), 8'($urandom));
      else begin
        int kind;
        kind = $urandom % 8;
        access(pick_addr(), kind < 5, kind == 5 || kind == 6, 8'($urandom), "R2");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule